// File: doc/BRIEF.md
# I2C Target Port with Address Match

This block is the target side of a two-wire serial bus. It watches the clock and data lines, recognises START and STOP, and compares each incoming address byte with a 7-bit address that software programs. When the address matches, the port acknowledges. It then either receives bytes into a one-byte data register or sends bytes from it. An address byte of all zeros (general call) can optionally be accepted as well.

A small register bus connects the port to the processor. It carries the data register, a status register whose sticky flags are cleared by writing 1, a control register, and the own-address register. After every byte the port raises an interrupt request. While sending, it holds the clock line low between bytes until software has loaded the next byte and written the release bit.

A received byte that finds the data register still full is refused with a NACK and recorded in an overflow flag. A sleep input lets an address match wake the system; an address that does not match leaves it asleep.

Register map (`reg_addr`):
- 0 = data. A write loads it. A read returns it and clears the full flag.
- 1 = status. Bit 0 interrupt, bit 1 full, bit 2 overflow, bit 3 START seen, bit 4 direction, bit 5 wake. Bits 0, 2 and 5 are cleared by writing 1.
- 2 = control. Bit 0 enables general call. Writing 1 to bit 1 releases the held clock; this bit is not stored.
- 3 = own address, held in bits 7:1.

Top module: `i2c_slave_port`

## Requirements
- R1: An address byte whose bits 7:1 equal bits 7:1 of register 3 is acknowledged by driving SDA low during the ninth clock. Any other address (apart from R2) gets no acknowledge, and the port ignores the bus until the next START.
- R2: When control bit 0 is set, an address byte of 0x00 is acknowledged and stored so that register 0 reads 0x00. When control bit 0 is clear, 0x00 is not acknowledged.
- R3: Status bit 0 and the `irq` output are set on the falling edge of the ninth SCL pulse of every accepted address byte and every data byte. They stay set until software writes 1 to status bit 0.
- R4: A data byte that arrives while the full flag (status bit 1) or the overflow flag (status bit 2) is set gets no acknowledge and leaves register 0 unchanged. If the full flag was set, the overflow flag is set.
- R5: Status bit 3 is set by a START and cleared by a STOP.
- R6: Status bit 4 holds bit 0 of the last matched address byte (1 = the port sends).
- R7: After a matched address with bit 0 = 1, and after each byte the controller acknowledges, the port holds SCL low until control bit 1 is written with 1. It then sends register 0 MSB first.
- R8: If the controller does not acknowledge a sent byte, the port releases both lines and answers nothing until the next START.
- R9: An address match while `sleep_i` is high sets status bit 5 and `wake_o`. A mismatch does not. Writing 1 to status bit 5 clears both.
- R10: A read of register 0 clears the full flag. A received or written byte sets it.
- R11: After reset every status bit is 0, `irq` and `wake_o` are low, and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| scl_oe | output | 1 | Pull SCL low (clock hold) |
| sda_oe | output | 1 | Pull SDA low (acknowledge or data 0) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq | output | 1 | Interrupt request |
| sleep_i | input | 1 | System is powered down |
| wake_o | output | 1 | Wake-up request |

## Verification
The checker watches the rules that hold on every cycle. The interrupt flag stays set until it is cleared by a write. A STOP clears the START flag. The clock hold persists until a release write or a bus condition. The wake flag only rises while the system sleeps. An overflow never comes with an acknowledge and never changes the data register. Whether an address matches, whether general call is accepted, the bit order of sent bytes, and the return to idle after a controller NACK all depend on whole byte transfers. Only the bench's bus scenarios can show those, by sampling the acknowledge slot and the returned data.

// File: rtl/i2c_sl_pkg.sv
package i2c_sl_pkg;
    localparam int BYTE_W = 8;
    localparam int ADR_W  = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_HOLD
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] dat;
        logic [ADR_W-1:0]  own;
        logic              full;
        logic              ovf;
        logic              irq;
        logic              start;
        logic              rw;
        logic              wake;
        logic              gc_en;
        logic              sda_oe;
        logic              scl_oe;
        logic              mnack;
    } slv_s;
endpackage

// File: rtl/i2c_sl_lines.sv
module i2c_sl_lines #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] scl_d, scl_q, sda_d, sda_q;
    logic              sclp_d, sclp_q, sdap_d, sdap_q;
    logic              scl_s;

    assign scl_s = scl_q[TOP];
    assign sda_s = sda_q[TOP];

    always_comb begin
        scl_d  = {scl_q[STAGES-2:0], scl_i};
        sda_d  = {sda_q[STAGES-2:0], sda_i};
        sclp_d = scl_s;
        sdap_d = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q  <= '1;
            sda_q  <= '1;
            sclp_q <= 1'b1;
            sdap_q <= 1'b1;
        end else begin
            scl_q  <= scl_d;
            sda_q  <= sda_d;
            sclp_q <= sclp_d;
            sdap_q <= sdap_d;
        end
    end

    assign scl_rise  = scl_s & ~sclp_q;
    assign scl_fall  = ~scl_s & sclp_q;
    assign start_det = scl_s & sclp_q & sdap_q & ~sda_s;
    assign stop_det  = scl_s & sclp_q & ~sdap_q & sda_s;
endmodule

// File: rtl/i2c_sl_match.sv
module i2c_sl_match
    import i2c_sl_pkg::*;
(
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic [ADR_W-1:0]  own,
    input  logic              gc_en,
    output logic              hit
);
    logic own_hit, gc_hit;
    assign own_hit = (addr_byte[BYTE_W-1:1] == own);
    assign gc_hit  = gc_en && (addr_byte == '0);
    assign hit     = own_hit | gc_hit;
endmodule

// File: rtl/i2c_slave_port.sv
module i2c_slave_port
    import i2c_sl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              sleep_i,
    output logic              wake_o
);
    localparam logic [1:0] RA_DATA = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_CTRL = 2'd2;
    localparam logic [1:0] RA_OWN  = 2'd3;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    slv_s r_q, r_d;
    logic sda_s, scl_rise, scl_fall, start_det, stop_det, hit;
    logic release_wr, accept;
    logic start_flag, ovf_flag;
    logic [BYTE_W-1:0] dat_q;

    i2c_sl_lines #(.STAGES(SYNC_STAGES)) u_lines (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_sl_match u_match (
        .addr_byte(r_q.sh), .own(r_q.own), .gc_en(r_q.gc_en), .hit(hit)
    );

    assign release_wr = reg_we && (reg_addr == RA_CTRL) && reg_wdata[1];
    assign accept     = !r_q.full && !r_q.ovf;

    always_comb begin
        r_d = r_q;
        // processor side
        if (reg_we) begin
            unique case (reg_addr)
                RA_DATA: begin r_d.dat = reg_wdata; r_d.full = 1'b1; end
                RA_STAT: begin
                    if (reg_wdata[0]) r_d.irq  = 1'b0;
                    if (reg_wdata[2]) r_d.ovf  = 1'b0;
                    if (reg_wdata[5]) r_d.wake = 1'b0;
                end
                RA_CTRL: r_d.gc_en = reg_wdata[0];
                RA_OWN:  r_d.own   = reg_wdata[BYTE_W-1:1];
            endcase
        end
        if (reg_re && reg_addr == RA_DATA) r_d.full = 1'b0;
        // bus side
        if (start_det) begin
            r_d.st = ST_ADDR; r_d.cnt = '0; r_d.start = 1'b1;
            r_d.sda_oe = 1'b0; r_d.scl_oe = 1'b0;
        end else if (stop_det) begin
            r_d.st = ST_IDLE; r_d.start = 1'b0;
            r_d.sda_oe = 1'b0; r_d.scl_oe = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_ADDR, ST_RX: begin
                    if (scl_rise && r_q.cnt < ALL_BITS) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_s};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                    if (scl_fall && r_q.cnt == ALL_BITS) begin
                        if (r_q.st == ST_ADDR) begin
                            r_d.st = ST_IDLE;
                            if (hit) begin
                                r_d.rw = r_q.sh[0];
                                if (sleep_i) r_d.wake = 1'b1;
                                if (r_q.full) r_d.ovf = 1'b1;
                                if (accept) begin
                                    r_d.dat = r_q.sh; r_d.full = 1'b1;
                                    r_d.sda_oe = 1'b1; r_d.st = ST_ADDR_ACK;
                                end
                            end
                        end else begin
                            r_d.st = ST_RX_ACK;
                            if (r_q.full) r_d.ovf = 1'b1;
                            if (accept) begin
                                r_d.dat = r_q.sh; r_d.full = 1'b1; r_d.sda_oe = 1'b1;
                            end
                        end
                    end
                end
                ST_ADDR_ACK, ST_RX_ACK: if (scl_fall) begin
                    r_d.sda_oe = 1'b0; r_d.irq = 1'b1; r_d.cnt = '0;
                    if (r_q.st == ST_ADDR_ACK && r_q.rw) begin
                        r_d.st = ST_HOLD; r_d.scl_oe = 1'b1;
                    end else begin
                        r_d.st = ST_RX;
                    end
                end
                ST_HOLD: if (release_wr) begin
                    r_d.sh = r_q.dat; r_d.full = 1'b0; r_d.cnt = '0;
                    r_d.scl_oe = 1'b0; r_d.sda_oe = ~r_q.dat[BYTE_W-1];
                    r_d.st = ST_TX;
                end
                ST_TX: if (scl_fall) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == LAST_BIT) begin
                        r_d.sda_oe = 1'b0; r_d.st = ST_TX_ACK;
                    end else begin
                        r_d.sh = {r_q.sh[BYTE_W-2:0], 1'b0};
                        r_d.sda_oe = ~r_q.sh[BYTE_W-2];
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) r_d.mnack = sda_s;
                    if (scl_fall) begin
                        r_d.irq = 1'b1;
                        if (!r_q.mnack) begin
                            r_d.st = ST_HOLD; r_d.scl_oe = 1'b1;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_DATA: reg_rdata = r_q.dat;
            RA_STAT: reg_rdata = {2'b00, r_q.wake, r_q.rw, r_q.start, r_q.ovf, r_q.full, r_q.irq};
            RA_CTRL: reg_rdata = {{(BYTE_W-1){1'b0}}, r_q.gc_en};
            default: reg_rdata = {r_q.own, 1'b0};
        endcase
    end

    assign scl_oe     = r_q.scl_oe;
    assign sda_oe     = r_q.sda_oe;
    assign irq        = r_q.irq;
    assign wake_o     = r_q.wake;
    assign start_flag = r_q.start;
    assign ovf_flag   = r_q.ovf;
    assign dat_q      = r_q.dat;
endmodule

// File: rtl/i2c_slave_port_chk.sv
module i2c_slave_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       irq,
    input logic       sleep_i,
    input logic       wake_o,
    input logic       sda_oe,
    input logic       scl_oe,
    input logic       start_det,
    input logic       stop_det,
    input logic       start_flag,
    input logic       ovf_flag,
    input logic [7:0] dat_q
);
    logic irq_clr, rel_wr;
    assign irq_clr = reg_we && reg_addr == 2'd1 && reg_wdata[0];
    assign rel_wr  = reg_we && reg_addr == 2'd2 && reg_wdata[1];

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> irq); // R3
    AST_STOP_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && !start_det |=> !start_flag); // R5
    AST_OVF_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> !sda_oe); // R4
    AST_OVF_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) && !$past(reg_we) |-> $stable(dat_q)); // R4
    AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe && !rel_wr && !start_det && !stop_det |=> scl_oe); // R7
    AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(sleep_i)); // R9
endmodule

bind i2c_slave_port i2c_slave_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq(irq), .sleep_i(sleep_i), .wake_o(wake_o),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .start_det(start_det), .stop_det(stop_det),
    .start_flag(start_flag), .ovf_flag(ovf_flag), .dat_q(dat_q)
);

// File: tb/i2c_slave_port_bench.sv
module i2c_slave_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic reg_we = 1'b0, reg_re = 1'b0, sleep_i = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic scl_oe, sda_oe, irq, wake_o;
    wire  scl_line = m_scl & ~scl_oe;
    wire  sda_line = m_sda & ~sda_oe;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_slave_port u_i2c_slave_port (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sleep_i(sleep_i), .wake_o(wake_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_re = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_re = 1'b0;
    endtask

    task automatic bus_start;
        m_sda = 1'b1; m_scl = 1'b1; wt(8); m_sda = 1'b0; wt(8); m_scl = 1'b0; wt(8);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wt(8); m_scl = 1'b1; wt(8); m_sda = 1'b1; wt(8);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        m_sda = b; wt(8); m_scl = 1'b1;
        while (!scl_line) wt(1);
        wt(4); s = sda_line; wt(4); m_scl = 1'b0; wt(8);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(d[i], s);
        clock_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic s;
        for (int i = 0; i < 8; i++) begin clock_bit(1'b1, s); d = {d[6:0], s}; end
        clock_bit(nack, s);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        cpu_rd(2'd1, v); chk("R11 status", v, 8'h00);
        chk("R11 lines", {6'd0, scl_oe, sda_oe}, 8'h00);
        chk("R11 irq/wake", {6'd0, irq, wake_o}, 8'h00);
    endtask

    task automatic t_write_path;
        logic ack; logic [7:0] v;
        cpu_wr(2'd3, 8'hB4);
        bus_start;
        cpu_rd(2'd1, v); chk("R5 start set", v & 8'h08, 8'h08);
        send_byte(8'hB4, ack); chk("R1 match ack", {7'd0, ack}, 8'h01);
        cpu_rd(2'd1, v); chk("R3 irq after addr", v & 8'h01, 8'h01);
        chk("R6 rw write", v & 8'h10, 8'h00);
        cpu_rd(2'd0, v); chk("R1 addr byte in data", v, 8'hB4);
        cpu_rd(2'd1, v); chk("R10 full cleared by read", v & 8'h02, 8'h00);
        cpu_wr(2'd1, 8'h01);
        chk("R3 irq cleared", {7'd0, irq}, 8'h00);
        send_byte(8'h3C, ack); chk("R1 data ack", {7'd0, ack}, 8'h01);
        chk("R3 irq after data", {7'd0, irq}, 8'h01);
        cpu_wr(2'd1, 8'h01);
        send_byte(8'hC3, ack); chk("R4 nack when full", {7'd0, ack}, 8'h00);
        cpu_rd(2'd1, v); chk("R4 ovf set", v & 8'h04, 8'h04);
        chk("R3 irq on refused byte", v & 8'h01, 8'h01);
        cpu_rd(2'd0, v); chk("R4 data kept", v, 8'h3C);
        send_byte(8'h77, ack); chk("R4 nack while ovf", {7'd0, ack}, 8'h00);
        cpu_rd(2'd0, v); chk("R4 data kept under ovf", v, 8'h3C);
        bus_stop;
        cpu_rd(2'd1, v); chk("R5 stop clears start", v & 8'h08, 8'h00);
        cpu_wr(2'd1, 8'h25);
    endtask

    task automatic t_mismatch;
        logic ack; logic [7:0] v;
        bus_start;
        send_byte(8'hB6, ack); chk("R1 mismatch nack", {7'd0, ack}, 8'h00);
        send_byte(8'hB4, ack); chk("R1 ignored until start", {7'd0, ack}, 8'h00);
        cpu_rd(2'd1, v); chk("R1 no irq on mismatch", v & 8'h01, 8'h00);
        bus_stop;
    endtask

    task automatic t_gcall;
        logic ack; logic [7:0] v;
        bus_start; send_byte(8'h00, ack); bus_stop;
        chk("R2 gc disabled nack", {7'd0, ack}, 8'h00);
        cpu_wr(2'd2, 8'h01);
        bus_start; send_byte(8'h00, ack); bus_stop;
        chk("R2 gc enabled ack", {7'd0, ack}, 8'h01);
        cpu_rd(2'd0, v); chk("R2 gc byte readable", v, 8'h00);
        cpu_wr(2'd1, 8'h25);
    endtask

    task automatic t_read_path;
        logic ack; logic [7:0] v;
        bus_start;
        send_byte(8'hB5, ack); chk("R1 read addr ack", {7'd0, ack}, 8'h01);
        cpu_rd(2'd1, v); chk("R6 rw read", v & 8'h10, 8'h10);
        wt(20); chk("R7 hold after addr", {7'd0, scl_oe}, 8'h01);
        cpu_rd(2'd0, v);
        cpu_wr(2'd0, 8'hA5); wt(20);
        chk("R7 hold until release", {7'd0, scl_oe}, 8'h01);
        cpu_wr(2'd1, 8'h01);
        cpu_wr(2'd2, 8'h03);
        recv_byte(1'b0, v); chk("R7 first byte MSB first", v, 8'hA5);
        wt(20); chk("R7 hold after ack", {7'd0, scl_oe}, 8'h01);
        chk("R3 irq after sent byte", {7'd0, irq}, 8'h01);
        cpu_wr(2'd1, 8'h01);
        cpu_wr(2'd0, 8'h96);
        cpu_wr(2'd2, 8'h03);
        recv_byte(1'b1, v); chk("R7 second byte", v, 8'h96);
        wt(20); chk("R8 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
        send_byte(8'hB4, ack); chk("R8 idle after nack", {7'd0, ack}, 8'h00);
        bus_stop;
        cpu_wr(2'd1, 8'h25);
    endtask

    task automatic t_wake;
        logic ack; logic [7:0] v;
        sleep_i = 1'b1;
        bus_start; send_byte(8'hB6, ack); bus_stop;
        chk("R9 no wake on mismatch", {7'd0, wake_o}, 8'h00);
        bus_start; send_byte(8'hB4, ack); bus_stop;
        chk("R9 wake on match", {7'd0, wake_o}, 8'h01);
        cpu_rd(2'd1, v); chk("R9 wake flag", v & 8'h20, 8'h20);
        cpu_wr(2'd1, 8'h20);
        chk("R9 wake cleared", {7'd0, wake_o}, 8'h00);
        sleep_i = 1'b0;
        cpu_rd(2'd0, v);
        cpu_wr(2'd1, 8'h25);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run;
    end

    initial begin
        wt(4); rst_n = 1'b1; wt(4);
        t_reset;
        t_write_path;
        t_mismatch;
        t_gcall;
        t_read_path;
        t_wake;
        finish_run;
    end
endmodule